// File: doc/BRIEF.md
# Masked Sticky Interrupt Status Unit

This block gathers the single-cycle event pulses of a packet-mode serial bus master and of its transmit and receive FIFOs. Each pulse sets a status bit that stays set. There are eight event sources, each with a fixed bit position. Software reads the status word and clears any bit by writing a 1 to it. An enable word, which resets to all zeros, selects which status bits may raise the single interrupt line.

A wrapper-level "done" flag sits beside the event bits. It is set by its own pulse, sits at bit 30 of its own status word, and is cleared by writing a 1 there. It reaches the interrupt line only when its enable bit is set. That enable bit is bit 30 of a wrapper control word. The interrupt line is registered. It follows the status and enable state one clock later.

The register port is one-cycle and write-only in time. Reads are a combinational mux on `reg_addr`. Register select: 0 = event status, 1 = event enable, 2 = wrapper status, 3 = wrapper control. The decode is written as an enumerated select with four named cases. Those cases are EVT_STAT, EVT_EN, WRAP_STAT and WRAP_CTL. The block holds no state machine beyond the per-bit sticky transitions: set on a pulse, clear on a write of 1, hold otherwise.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is 0.
- R2: A pulse on `evt_pulse[i]` sets event status bit i, and the bit stays set until cleared. The bit map is: 7 packet transfer complete, 6 all packets complete, 5 transmit overflow, 4 receive underflow, 3 missing acknowledge, 2 arbitration lost, 1 transmit FIFO data request, 0 receive FIFO data request.
- R3: A write to the event status register clears exactly the bits written as 1 and leaves the other bits unchanged. Writing 0xFF clears all eight bits.
- R4: When an event pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: The event enable register holds bits 7:0 of the written data and reads back the same, with bits 31:8 reading 0. A set status bit whose enable bit is 0 never raises `irq`.
- R6: `irq` equals the OR over i of (status[i] AND enable[i]), ORed with (wrapper done AND wrapper enable). It is sampled at each clock edge, so it changes one cycle after the state that drives it.
- R7: `done_pulse` sets bit 30 of the wrapper status word. Writing 1 to bit 30 of that word clears it. A write with bit 30 at 0 leaves it set.
- R8: The wrapper enable is bit 30 of the wrapper control word. While it is 0, the done flag does not raise `irq`.
- R9: A write to one register leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | EVT_N | Event pulses, one per status bit |
| done_pulse | input | 1 | Wrapper done pulse |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register (combinational) |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with its default parameters: eight events, a 32-bit data word and the done flag at bit 30. With these values every named event position can be checked directly, and the wrapper bits are placed well above the event bits. That placement lets the bench show that the enable register drops the upper written bits and that a wrapper write with bit 30 clear does nothing. The directed scenarios sample `irq` in the first and second cycles after each set or clear, which pins down the one-cycle latency in both directions.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // event bit positions; software decodes these, so they are fixed
    localparam int EV_RX_REQ   = 0;
    localparam int EV_TX_REQ   = 1;
    localparam int EV_ARB_LOST = 2;
    localparam int EV_NACK     = 3;
    localparam int EV_RX_UNDER = 4;
    localparam int EV_TX_OVER  = 5;
    localparam int EV_ALL_PKT  = 6;
    localparam int EV_PKT_DONE = 7;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_EVT_STAT  = 2'd0,
        SEL_EVT_EN    = 2'd1,
        SEL_WRAP_STAT = 2'd2,
        SEL_WRAP_CTL  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // a set wins over a clear in the same cycle
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[g] <= 1'b0;
            else if (set_i[g])
                q_o[g] <= 1'b1;
            else if (clr_i[g])
                q_o[g] <= 1'b0;
        end

        assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> q_o[g]);
        assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[g] && !clr_i[g]) |=> q_o[g]);
        assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!q_o[g] && !set_i[g]) |=> !q_o[g]);
        assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !q_o[g]);
        assert_collide_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && set_i[g]) |=> q_o[g]);
    end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (we_i)
            q_o <= d_i;
    end

    assert_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(q_o));
    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (q_o == $past(d_i)));

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_pkg::*;
#(
    parameter int EVT_N    = 8,
    parameter int DATA_W   = 32,
    parameter int DONE_POS = 30
) (
    input  logic              wr_i,
    input  logic [SEL_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [EVT_N-1:0]  evt_stat_i,
    input  logic [EVT_N-1:0]  evt_en_i,
    input  logic              wrap_done_i,
    input  logic              wrap_en_i,
    output logic [EVT_N-1:0]  evt_clr_o,
    output logic              evt_en_we_o,
    output logic [EVT_N-1:0]  evt_en_d_o,
    output logic              wrap_clr_o,
    output logic              wrap_en_we_o,
    output logic              wrap_en_d_o,
    output logic [DATA_W-1:0] rdata_o
);

    reg_sel_e sel;
    assign sel         = reg_sel_e'(addr_i);
    assign evt_en_d_o  = wdata_i[EVT_N-1:0];
    assign wrap_en_d_o = wdata_i[DONE_POS];

    // write strobes
    always_comb begin
        evt_clr_o    = '0;
        evt_en_we_o  = 1'b0;
        wrap_clr_o   = 1'b0;
        wrap_en_we_o = 1'b0;
        if (wr_i) begin
            unique case (sel)
                SEL_EVT_STAT:  evt_clr_o    = wdata_i[EVT_N-1:0];
                SEL_EVT_EN:    evt_en_we_o  = 1'b1;
                SEL_WRAP_STAT: wrap_clr_o   = wdata_i[DONE_POS];
                SEL_WRAP_CTL:  wrap_en_we_o = 1'b1;
                default:       evt_en_we_o  = 1'b0;
            endcase
        end
    end

    // read mux
    always_comb begin
        rdata_o = '0;
        unique case (sel)
            SEL_EVT_STAT:  rdata_o[EVT_N-1:0] = evt_stat_i;
            SEL_EVT_EN:    rdata_o[EVT_N-1:0] = evt_en_i;
            SEL_WRAP_STAT: rdata_o[DONE_POS]  = wrap_done_i;
            SEL_WRAP_CTL:  rdata_o[DONE_POS]  = wrap_en_i;
            default:       rdata_o            = '0;
        endcase
    end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int EVT_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] stat_i,
    input  logic [EVT_N-1:0] en_i,
    input  logic             wrap_done_i,
    input  logic             wrap_en_i,
    output logic             irq_o
);

    logic evt_any;
    logic wrap_any;

    assign evt_any  = |(stat_i & en_i);
    assign wrap_any = wrap_done_i & wrap_en_i;

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= evt_any | wrap_any;
    end

    assert_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & en_i) == '0 && !(wrap_done_i && wrap_en_i)) |=> !irq_o);
    assert_wrap_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_done_i && wrap_en_i) |=> irq_o);
    assert_evt_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & en_i) != '0) |=> irq_o);

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int EVT_N    = 8,
    parameter int DATA_W   = 32,
    parameter int DONE_POS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_N-1:0]  evt_pulse,
    input  logic              done_pulse,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic [EVT_N-1:0] evt_stat;
    logic [EVT_N-1:0] evt_en;
    logic [EVT_N-1:0] evt_clr;
    logic             evt_en_we;
    logic [EVT_N-1:0] evt_en_d;
    logic             wrap_done;
    logic             wrap_en;
    logic             wrap_clr;
    logic             wrap_en_we;
    logic             wrap_en_d;

    irq_reg_decode #(
        .EVT_N   (EVT_N),
        .DATA_W  (DATA_W),
        .DONE_POS(DONE_POS)
    ) u_decode (
        .wr_i        (reg_wr),
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .evt_stat_i  (evt_stat),
        .evt_en_i    (evt_en),
        .wrap_done_i (wrap_done),
        .wrap_en_i   (wrap_en),
        .evt_clr_o   (evt_clr),
        .evt_en_we_o (evt_en_we),
        .evt_en_d_o  (evt_en_d),
        .wrap_clr_o  (wrap_clr),
        .wrap_en_we_o(wrap_en_we),
        .wrap_en_d_o (wrap_en_d),
        .rdata_o     (reg_rdata)
    );

    irq_sticky_bank #(.WIDTH(EVT_N)) u_evt_stat (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(evt_pulse),
        .clr_i(evt_clr),
        .q_o  (evt_stat)
    );

    irq_sticky_bank #(.WIDTH(1)) u_wrap_stat (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(done_pulse),
        .clr_i(wrap_clr),
        .q_o  (wrap_done)
    );

    irq_enable_reg #(.WIDTH(EVT_N)) u_evt_en (
        .clk  (clk),
        .rst_n(rst_n),
        .we_i (evt_en_we),
        .d_i  (evt_en_d),
        .q_o  (evt_en)
    );

    irq_enable_reg #(.WIDTH(1)) u_wrap_en (
        .clk  (clk),
        .rst_n(rst_n),
        .we_i (wrap_en_we),
        .d_i  (wrap_en_d),
        .q_o  (wrap_en)
    );

    irq_out_stage #(.EVT_N(EVT_N)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_i     (evt_stat),
        .en_i       (evt_en),
        .wrap_done_i(wrap_done),
        .wrap_en_i  (wrap_en),
        .irq_o      (irq)
    );

    // at most one register is written per cycle
    assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|evt_clr, evt_en_we, wrap_clr, wrap_en_we}));
    assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(evt_en) && $stable(wrap_en)));

endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;

    localparam int EVT_N  = 8;
    localparam int DATA_W = 32;
    localparam int DPOS   = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [EVT_N-1:0]  evt_pulse = '0;
    logic              done_pulse = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    int vec = 0;
    int err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    irq_status_unit #(.EVT_N(EVT_N), .DATA_W(DATA_W), .DONE_POS(DPOS)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .done_pulse(done_pulse),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [7:0] e, input logic dn);
        @(negedge clk);
        evt_pulse = e; done_pulse = dn;
        @(negedge clk);
        evt_pulse = '0; done_pulse = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_sticky;
        logic [31:0] v;
        logic [7:0]  acc = '0;
        for (int i = 0; i < EVT_N; i++) begin
            pulse(8'(1 << i), 1'b0);
            acc |= 8'(1 << i);
            rd(2'd0, v);
            chk("R2 status accumulates", v, {24'b0, acc});
        end
        repeat (3) @(negedge clk);
        rd(2'd0, v);
        chk("R2 status held", v, 32'hFF);
        chk("R5 masked, no irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(2'd0, 32'h0000_000A);
        rd(2'd0, v);
        chk("R3 partial clear", v, 32'hF5);
        rd(2'd1, v);
        chk("R9 enable untouched by status write", v, 32'h0);
        wr(2'd0, 32'h0000_00FF);
        rd(2'd0, v);
        chk("R3 clear all", v, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        pulse(8'h04, 1'b0);
        @(negedge clk);
        evt_pulse = 8'h24; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h24;
        @(negedge clk);
        evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd0, v);
        chk("R4 set wins over clear", v, 32'h24);
        wr(2'd0, 32'hFF);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(2'd1, 32'hFFFF_FF88);
        rd(2'd1, v);
        chk("R5 enable readback", v, 32'h88);
        pulse(8'h10, 1'b0);
        @(negedge clk);
        chk("R5 masked source no irq", {31'b0, irq}, 32'h0);
        @(negedge clk);
        evt_pulse = 8'h80;
        @(negedge clk);
        evt_pulse = '0;
        chk("R6 irq not yet raised", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R6 irq raised one cycle later", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h80);
        chk("R6 irq still high in clear cycle", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R6 irq drops one cycle later", {31'b0, irq}, 32'h0);
        rd(2'd0, v);
        chk("R2 masked bit stays set", v, 32'h10);
    endtask

    task automatic t_done;
        logic [31:0] v;
        pulse(8'h00, 1'b1);
        rd(2'd2, v);
        chk("R7 done flag set", v, 32'h4000_0000);
        @(negedge clk);
        chk("R8 done gated off", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'hBFFF_FFFF);
        rd(2'd2, v);
        chk("R7 write with bit30 clear keeps flag", v, 32'h4000_0000);
        wr(2'd3, 32'h4000_0000);
        rd(2'd3, v);
        chk("R8 wrapper enable readback", v, 32'h4000_0000);
        @(negedge clk);
        chk("R8 enabled done raises irq", {31'b0, irq}, 32'h1);
        wr(2'd2, 32'h4000_0000);
        rd(2'd2, v);
        chk("R7 done flag cleared", v, 32'h0);
        @(negedge clk);
        chk("R6 irq low after done clear", {31'b0, irq}, 32'h0);
        rd(2'd0, v);
        chk("R9 event status untouched", v, 32'h10);
        rd(2'd1, v);
        chk("R9 event enable untouched", v, 32'h88);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_clear();
        t_collide();
        t_mask();
        t_done();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            vec++;
            err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, err);
            $finish;
        end
    end

endmodule